// File: doc/BRIEF.md
# Serial Bus ROM Search Responder

This block is the device side of a bit-by-bit discovery search on a shared single-wire bus. It holds a fixed identity word (`ROM_BITS` bits, default 64) and reacts to slot strobes that a separate physical-layer front end produces: a read-slot strobe, a write-slot strobe with the sampled bit, and a bus-reset strobe. Its only bus output is an open-drain pull-low enable. A released line reads as 1, so several responders on one wire combine as a wired AND.

After a bus reset the responder collects one command byte over eight write slots, least-significant bit first. If the byte is the search command, it walks the identity word from bit 0 upward. For each position it answers the first read slot with the true bit and the second with its complement. It then compares the master's next written bit against its own. A mismatch drops it out of the search until the next bus reset. A device that survives every position switches to reporting the level of one input pin on each further read slot.

Top module: `rom_search_responder`

## Requirements
- R1: After `rst_n` is released, the block waits for a command byte, and `pullLow` stays 0 on read slots while the byte is being collected.
- R2: The command byte is taken from eight write slots, least-significant bit first. A byte equal to `SEARCH_CMD` (default 8'hF0) starts the search at identity bit 0. Any other byte makes the block release the bus on every slot until the next bus reset.
- R3: On the first read slot of a bit position, `pullLow` is 1 exactly when identity bit `ROM_ID[i]` is 0, where i is the current position.
- R4: On the second read slot of the same position, `pullLow` is 1 exactly when `ROM_ID[i]` is 1.
- R5: Any further read slot at the same position, before the write slot, leaves the bus released.
- R6: A write slot whose bit equals `ROM_ID[i]` advances the search to position i+1, starting again with the true-bit read.
- R7: A write slot whose bit differs from `ROM_ID[i]` deselects the block. From then on, every read slot releases the bus and write slots have no effect until the next bus reset.
- R8: Once the bit at position `ROM_BITS-1` has been matched, every read slot drives `pullLow` to 1 exactly when `pioIn` is 0. Write slots are then ignored.
- R9: A `busReset` strobe returns the block to command collection, reselects it, and clears the position. It wins over any slot strobe in the same cycle, and the bus stays released in that cycle.
- R10: `pullLow` is a combinational answer inside the read-slot cycle. It is never 1 in a cycle without `readSlot`.
- R11: When `readSlot` and `writeSlot` arrive in the same cycle, the read is served and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | One-cycle strobe: bus reset seen by the front end |
| readSlot | input | 1 | One-cycle strobe: a read slot is in progress |
| writeSlot | input | 1 | One-cycle strobe: a write slot was sampled |
| writeBit | input | 1 | Bit value sampled in the write slot |
| pioIn | input | 1 | Pin whose level is reported after a full match |
| pullLow | output | 1 | Open-drain enable; 1 pulls the bus line low |

## Verification
A wrong position count or a wrong phase shows up on `pullLow` at the very next read slot. The true and complement answers for a bit are opposite in polarity, so an off-by-one phase swaps them at once. An off-by-one position shows up within a few bits of the patterned identity word. A deselect that fails to stick, or a command byte that is decoded wrongly, shows up as a pull-low where a released line is expected, on the first read slot after the event. An early or late hand-over to pin reporting shows up on the read slot at the last position.

// File: rtl/rom_search_pkg.sv
package rom_search_pkg;
  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,
    ST_SEARCH = 2'd1,
    ST_PIO    = 2'd2,
    ST_OFF    = 2'd3
  } respState_t;

  typedef enum logic [1:0] {
    PH_TRUE = 2'd0,
    PH_COMP = 2'd1,
    PH_WAIT = 2'd2
  } bitPhase_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftCmd;
  } dpCtl_t;
endpackage

// File: rtl/search_datapath.sv
module search_datapath
  import rom_search_pkg::*;
#(
  parameter int ROM_BITS = 64,
  parameter logic [ROM_BITS-1:0] ROM_ID = '0,
  parameter logic [7:0] SEARCH_CMD = 8'hF0,
  localparam int CNT_W = $clog2(ROM_BITS)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  dpCtl_t dpCtl,
  input  logic   writeBit,
  output logic   romBit,
  output logic   lastBit,
  output logic   cmdLast,
  output logic   cmdMatch
);
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] cmdReg;
  logic [7:0] cmdNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
      cmdReg <= '0;
    end else begin
      if (dpCtl.clrCnt) bitCnt <= '0;
      else if (dpCtl.incCnt) bitCnt <= bitCnt + 1'b1;
      if (dpCtl.shiftCmd) cmdReg <= cmdNext;
    end
  end

  always_comb begin
    cmdNext  = {writeBit, cmdReg[7:1]};
    romBit   = ROM_ID[bitCnt];
    lastBit  = (bitCnt == CNT_W'(ROM_BITS - 1));
    cmdLast  = (bitCnt == CNT_W'(7));
    cmdMatch = (cmdNext == SEARCH_CMD);
  end
endmodule

// File: rtl/search_ctrl.sv
module search_ctrl
  import rom_search_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReset,
  input  logic       readSlot,
  input  logic       writeSlot,
  input  logic       writeBit,
  input  logic       pioIn,
  input  logic       romBit,
  input  logic       lastBit,
  input  logic       cmdLast,
  input  logic       cmdMatch,
  output dpCtl_t     dpCtl,
  output respState_t curState,
  output logic       pullLow
);
  respState_t nextState;
  bitPhase_t  phase, nextPhase;
  logic       wrEvent;
  logic       driveLow;

  assign wrEvent = writeSlot && !readSlot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState <= ST_CMD;
      phase    <= PH_TRUE;
    end else begin
      curState <= nextState;
      phase    <= nextPhase;
    end
  end

  always_comb begin
    nextState = curState;
    nextPhase = phase;
    dpCtl     = '0;
    if (busReset) begin
      nextState    = ST_CMD;
      nextPhase    = PH_TRUE;
      dpCtl.clrCnt = 1'b1;
    end else if (readSlot) begin
      if (curState == ST_SEARCH) begin
        if (phase == PH_TRUE) nextPhase = PH_COMP;
        else if (phase == PH_COMP) nextPhase = PH_WAIT;
      end
    end else if (wrEvent) begin
      unique case (curState)
        ST_CMD: begin
          dpCtl.shiftCmd = 1'b1;
          if (cmdLast) begin
            dpCtl.clrCnt = 1'b1;
            nextPhase    = PH_TRUE;
            nextState    = cmdMatch ? ST_SEARCH : ST_OFF;
          end else begin
            dpCtl.incCnt = 1'b1;
          end
        end
        ST_SEARCH: begin
          if (writeBit != romBit) begin
            nextState = ST_OFF;
          end else if (lastBit) begin
            nextState = ST_PIO;
          end else begin
            dpCtl.incCnt = 1'b1;
            nextPhase    = PH_TRUE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    driveLow = 1'b0;
    unique case (curState)
      ST_SEARCH: begin
        if (phase == PH_TRUE) driveLow = !romBit;
        else if (phase == PH_COMP) driveLow = romBit;
      end
      ST_PIO:  driveLow = !pioIn;
      default: driveLow = 1'b0;
    endcase
  end

  assign pullLow = readSlot && !busReset && driveLow;
endmodule

// File: rtl/rom_search_responder.sv
module rom_search_responder
  import rom_search_pkg::*;
#(
  parameter int ROM_BITS = 64,
  parameter logic [ROM_BITS-1:0] ROM_ID = 64'hA5C3_0F1E_7B29_4D86,
  parameter logic [7:0] SEARCH_CMD = 8'hF0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busReset,
  input  logic readSlot,
  input  logic writeSlot,
  input  logic writeBit,
  input  logic pioIn,
  output logic pullLow
);
  dpCtl_t     dpCtl;
  respState_t curState;
  logic romBit, lastBit, cmdLast, cmdMatch;

  search_datapath #(
    .ROM_BITS(ROM_BITS), .ROM_ID(ROM_ID), .SEARCH_CMD(SEARCH_CMD)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtl(dpCtl), .writeBit(writeBit),
    .romBit(romBit), .lastBit(lastBit), .cmdLast(cmdLast), .cmdMatch(cmdMatch)
  );

  search_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .readSlot(readSlot),
    .writeSlot(writeSlot), .writeBit(writeBit), .pioIn(pioIn),
    .romBit(romBit), .lastBit(lastBit), .cmdLast(cmdLast), .cmdMatch(cmdMatch),
    .dpCtl(dpCtl), .curState(curState), .pullLow(pullLow)
  );
endmodule

// File: rtl/rom_search_checker.sv
module rom_search_checker
  import rom_search_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busReset,
  input logic       readSlot,
  input logic       writeSlot,
  input logic       writeBit,
  input logic       pioIn,
  input logic       romBit,
  input logic       pullLow,
  input respState_t curState
);
  assert_no_pull_outside_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !readSlot |-> !pullLow);

  assert_reset_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> (curState == ST_CMD));

  assert_deselect_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_OFF && !busReset) |=> (curState == ST_OFF));

  assert_mismatch_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_SEARCH && writeSlot && !readSlot && !busReset && writeBit != romBit)
      |=> (curState == ST_OFF));

  assert_released_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_OFF) |-> !pullLow);

  assert_pio_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_PIO && readSlot && !busReset) |-> (pullLow == !pioIn));

  assert_pio_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_PIO && !busReset) |=> (curState == ST_PIO));
endmodule

bind rom_search_responder rom_search_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busReset(busReset), .readSlot(readSlot),
  .writeSlot(writeSlot), .writeBit(writeBit), .pioIn(pioIn),
  .romBit(romBit), .pullLow(pullLow), .curState(curState)
);

// File: tb/rom_search_responder_test.sv
module rom_search_responder_test;
  localparam int PERIOD = 10;
  localparam logic [63:0] ID = 64'h3C5A_96E1_0F72_B84D;
  localparam logic [7:0] CMD = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busReset = 1'b0, readSlot = 1'b0, writeSlot = 1'b0, writeBit = 1'b0, pioIn = 1'b1;
  logic pullLow;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model: 0 cmd, 1 search, 2 pio, 3 off
  int mState = 0, mCnt = 0, mPhase = 0, mCmd = 0;

  rom_search_responder #(.ROM_BITS(64), .ROM_ID(ID), .SEARCH_CMD(CMD)) uut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .readSlot(readSlot),
    .writeSlot(writeSlot), .writeBit(writeBit), .pioIn(pioIn), .pullLow(pullLow)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic bit expPull(bit br, bit rs);
    if (br || !rs) return 0;
    if (mState == 1) begin
      if (mPhase == 0) return !ID[mCnt];
      if (mPhase == 1) return ID[mCnt];
      return 0;
    end
    if (mState == 2) return !pioIn;
    return 0;
  endfunction

  task automatic modelStep(bit br, bit rs, bit ws, bit wb);
    if (br) begin
      mState = 0; mCnt = 0; mPhase = 0; mCmd = 0;
    end else if (rs) begin
      if (mState == 1 && mPhase < 2) mPhase++;
    end else if (ws) begin
      if (mState == 0) begin
        mCmd = mCmd | (int'(wb) << mCnt);
        if (mCnt == 7) begin
          mState = (mCmd == int'(CMD)) ? 1 : 3;
          mCnt = 0; mPhase = 0;
        end else mCnt++;
      end else if (mState == 1) begin
        if (wb != ID[mCnt]) mState = 3;
        else if (mCnt == 63) mState = 2;
        else begin mCnt++; mPhase = 0; end
      end
    end
  endtask

  task automatic cycle(bit br, bit rs, bit ws, bit wb, string tag);
    bit e;
    @(negedge clk);
    busReset = br; readSlot = rs; writeSlot = ws; writeBit = wb;
    #1;
    e = expPull(br, rs);
    checks++;
    if (pullLow !== e) begin
      fails++;
      $display("FAIL %s: pullLow=%b expected=%b (state %0d pos %0d)", tag, pullLow, e, mState, mCnt);
    end
    @(posedge clk);
    modelStep(br, rs, ws, wb);
  endtask

  task automatic sendByte(logic [7:0] b, string tag);
    for (int i = 0; i < 8; i++) cycle(0, 0, 1, b[i], tag);
  endtask

  task automatic searchBit(bit wb);
    cycle(0, 1, 0, 0, "R3");
    cycle(0, 1, 0, 0, "R4");
    cycle(0, 0, 0, 0, "R10");
    cycle(0, 0, 1, wb, "R6");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, reads while collecting command
    cycle(0, 1, 0, 0, "R1");
    cycle(0, 0, 0, 0, "R1");
    // R2: wrong command -> ignore everything
    sendByte(8'h33, "R2");
    for (int i = 0; i < 4; i++) cycle(0, 1, 0, 0, "R2");
    cycle(0, 0, 1, 0, "R2");
    cycle(0, 1, 0, 0, "R2");
    // R9: reset together with read slot
    cycle(1, 1, 0, 0, "R9");
    sendByte(CMD, "R2");
    // first bits with extra reads (R5) and simultaneous slots (R11)
    cycle(0, 1, 0, 0, "R3");
    cycle(0, 1, 0, 0, "R4");
    cycle(0, 1, 0, 0, "R5");
    cycle(0, 1, 1, !ID[0], "R11");
    cycle(0, 1, 0, 0, "R5");
    cycle(0, 0, 1, ID[0], "R6");
    for (int i = 1; i < 64; i++) searchBit(ID[i]);
    // R8: pin reporting
    pioIn = 1'b0;
    cycle(0, 1, 0, 0, "R8");
    cycle(0, 0, 1, 1, "R8");
    pioIn = 1'b1;
    cycle(0, 1, 0, 0, "R8");
    pioIn = 1'b0;
    cycle(0, 1, 0, 0, "R8");
    // R9: new pass, mismatch at bit 5 (R7)
    cycle(1, 0, 0, 0, "R9");
    cycle(0, 1, 0, 0, "R9");
    sendByte(CMD, "R2");
    for (int i = 0; i < 5; i++) searchBit(ID[i]);
    cycle(0, 1, 0, 0, "R3");
    cycle(0, 1, 0, 0, "R4");
    cycle(0, 0, 1, !ID[5], "R7");
    for (int i = 0; i < 6; i++) cycle(0, 1, 0, 0, "R7");
    cycle(0, 0, 1, ID[5], "R7");
    cycle(0, 1, 0, 0, "R7");
    // reselect after reset, walk a few bits with other pio level
    pioIn = 1'b1;
    cycle(1, 0, 1, 1, "R9");
    sendByte(CMD, "R9");
    for (int i = 0; i < 10; i++) searchBit(ID[i]);
    cycle(0, 1, 0, 0, "R3");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule